// File: doc/BRIEF.md
# Logic Analyzer Serial Command Decoder

This block turns a stream of received bytes from a serial link into configuration actions for a logic-analyzer capture engine. Each byte is handed over with a one-cycle valid strobe. The decoder frames the bytes into commands of two sizes. A command whose opcode has bit 7 clear is a single byte. A command whose opcode has bit 7 set is followed by a 32-bit argument, carried in four bytes with the most significant byte first.

Single-byte commands raise one-cycle strobes for acquisition start, soft reset and metadata request. A further single-byte command raises an identification strobe and sends a fixed four-byte reply through a valid/ready transmit port. Five-byte commands become a single-cycle register write. The write carries a compact register index and the 32-bit argument. The registers it can address are the sample-rate divider, the capture size, the flags, and the mask, value and configuration words of each trigger stage. The capture engine owns the meaning of the fields. For example, rate = clock/(divider+1), doubled when demux is set. The capture size holds (read count − 1) in its upper half and (delay count − 1) in its lower half. Flag bits 2..5 each switch off one byte-wide channel group. The decoder passes these words through without changing them.

A zero byte in the opcode position is a reset. Five zero bytes in a row therefore always bring the framing back into step, whatever byte of a partial long command the decoder was waiting for.

Top module: `logic_cmd_decoder`

## Requirements
- R1: A received byte with bit 7 clear is a complete command on its own. Its strobe is high in exactly the one cycle that follows the clock edge at which the byte was taken.
- R2: A byte with bit 7 set, taken in the opcode position, starts a long command. The next four bytes form the argument, most significant byte first. The write strobe `wr_en` rises in the cycle after the fifth byte, with `wr_data` equal to that argument.
- R3: Opcode 0x00 raises `reset_pulse`, and the decoder is then waiting for an opcode.
- R4: Five consecutive 0x00 bytes leave the decoder waiting for an opcode, from any byte position. A partial long command that they complete is written with zero argument bytes, and every 0x00 left over in the opcode position raises `reset_pulse`.
- R5: Opcode 0x01 raises `run_pulse`.
- R6: Opcode 0x04 raises `meta_pulse`.
- R7: Opcode 0x02 raises `id_pulse`. It then makes `tx_valid` offer the bytes 0x31, 0x53, 0x4C, 0x4F in that order. Each byte is held stable until it is taken with `tx_ready`.
- R8: Opcode 0x00 received while the identification reply is pending cancels the reply. `tx_valid` is low from the second cycle after the reset byte is taken.
- R9: Opcode 0x02 received while a reply is pending raises `id_pulse` but neither restarts nor extends the reply. Exactly four bytes go out.
- R10: `wr_addr` maps the long opcodes as follows:
  - 0x80 (divider) → 0
  - 0x81 (capture size) → 1
  - 0x82 (flags) → 2
  - 0xC0 + 4·s + k → 3 + 3·s + k, for trigger stage s < NUM_STAGES and word k ∈ {0 mask, 1 value, 2 config}.
- R11: An unrecognised long opcode (including k = 3 and s ≥ NUM_STAGES) still consumes its four argument bytes and raises no strobe. An unrecognised short opcode raises no strobe.
- R12: After reset all strobes and `tx_valid` are low. At most one of the five strobes is high in any cycle, and `wr_en` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| run_pulse | output | 1 | Start acquisition strobe |
| reset_pulse | output | 1 | Soft reset strobe |
| id_pulse | output | 1 | Identification request strobe |
| meta_pulse | output | 1 | Metadata request strobe |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | ADDR_W | Register index of the write |
| wr_data | output | 32 | Register write data |
| tx_valid | output | 1 | Reply byte offered |
| tx_ready | input | 1 | Reply byte accepted |
| tx_data | output | 8 | Reply byte |

## Verification
The assertions take for granted that `rx_valid` is a single-cycle strobe per byte and that the transmit sink never needs a byte to be re-offered after a cancel. The ready-hold property also assumes that a reset command and an identification command are not decoded in the same cycle, which holds because each is a separate byte. The stimulus sends bytes with one idle cycle between them. It raises `tx_ready` only from a gated pattern, and it stalls the sink completely while checking cancellation and repeated identification requests. The stall keeps each reply in a known, still-pending state when the second command arrives.

// File: rtl/cmd_pkg.sv
package cmd_pkg;

    localparam logic [7:0] OP_RESET   = 8'h00;
    localparam logic [7:0] OP_RUN     = 8'h01;
    localparam logic [7:0] OP_IDENT   = 8'h02;
    localparam logic [7:0] OP_META    = 8'h04;
    localparam logic [7:0] OP_DIVIDER = 8'h80;
    localparam logic [7:0] OP_CAPSIZE = 8'h81;
    localparam logic [7:0] OP_FLAGS   = 8'h82;

    localparam int ARG_BYTES  = 4;
    localparam int ARG_W      = 8 * ARG_BYTES;
    localparam int ID_LEN     = 4;
    localparam int ID_IDX_W   = $clog2(ID_LEN);
    localparam int FIXED_REGS = 3;
    localparam int WORDS_PER_STAGE = 3;

    typedef struct packed {
        logic [7:0]       op;
        logic [ARG_W-1:0] arg;
    } long_cmd_t;

    typedef struct packed {
        logic       hit;
        logic [7:0] index;
    } reg_map_t;

    function automatic logic [7:0] ident_byte(input logic [ID_IDX_W-1:0] idx);
        case (idx)
            2'd0:    return 8'h31;
            2'd1:    return 8'h53;
            2'd2:    return 8'h4C;
            default: return 8'h4F;
        endcase
    endfunction

    function automatic reg_map_t map_long(input logic [7:0] op, input int num_stages);
        reg_map_t m;
        int stage;
        int word;
        m.hit   = 1'b0;
        m.index = 8'd0;
        stage   = int'(op[5:2]);
        word    = int'(op[1:0]);
        if (op == OP_DIVIDER) begin
            m.hit = 1'b1; m.index = 8'd0;
        end else if (op == OP_CAPSIZE) begin
            m.hit = 1'b1; m.index = 8'd1;
        end else if (op == OP_FLAGS) begin
            m.hit = 1'b1; m.index = 8'd2;
        end else if (op[7:6] == 2'b11 && word < WORDS_PER_STAGE && stage < num_stages) begin
            m.hit   = 1'b1;
            m.index = 8'(FIXED_REGS + WORDS_PER_STAGE * stage + word);
        end
        return m;
    endfunction

endpackage

// File: rtl/cmd_framer.sv
module cmd_framer
    import cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       short_valid,
    output logic [7:0] short_op,
    output logic       long_valid,
    output long_cmd_t  long_cmd
);
    localparam int CNT_W = $clog2(ARG_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ARG_BYTES);

    logic [CNT_W-1:0] pos_q;
    logic [7:0]       op_q;
    logic [ARG_W-1:0] arg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q       <= '0;
            op_q        <= '0;
            arg_q       <= '0;
            short_valid <= 1'b0;
            short_op    <= '0;
            long_valid  <= 1'b0;
            long_cmd    <= '0;
        end else begin
            short_valid <= 1'b0;
            long_valid  <= 1'b0;
            if (rx_valid) begin
                if (pos_q == '0) begin
                    if (rx_data[7]) begin
                        op_q  <= rx_data;
                        arg_q <= '0;
                        pos_q <= CNT_W'(1);
                    end else begin
                        short_valid <= 1'b1;
                        short_op    <= rx_data;
                    end
                end else begin
                    arg_q <= {arg_q[ARG_W-9:0], rx_data};
                    if (pos_q == LAST) begin
                        long_valid   <= 1'b1;
                        long_cmd.op  <= op_q;
                        long_cmd.arg <= {arg_q[ARG_W-9:0], rx_data};
                        pos_q        <= '0;
                    end else begin
                        pos_q <= pos_q + CNT_W'(1);
                    end
                end
            end
        end
    end

    assert_zero_opcode_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && pos_q == '0 && rx_data == 8'h00) |=> (short_valid && short_op == 8'h00));

    assert_one_kind_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({short_valid, long_valid}));

endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
    import cmd_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              short_valid,
    input  logic [7:0]        short_op,
    input  logic              long_valid,
    input  long_cmd_t         long_cmd,
    output logic              run_o,
    output logic              reset_o,
    output logic              ident_o,
    output logic              meta_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [ARG_W-1:0]  wr_data_o
);
    reg_map_t map;

    always_comb begin
        run_o   = 1'b0;
        reset_o = 1'b0;
        ident_o = 1'b0;
        meta_o  = 1'b0;
        if (short_valid) begin
            case (short_op)
                OP_RESET: reset_o = 1'b1;
                OP_RUN:   run_o   = 1'b1;
                OP_IDENT: ident_o = 1'b1;
                OP_META:  meta_o  = 1'b1;
                default:  ;
            endcase
        end
    end

    always_comb begin
        map       = map_long(long_cmd.op, NUM_STAGES);
        wr_en_o   = long_valid && map.hit;
        wr_addr_o = ADDR_W'(map.index);
        wr_data_o = long_cmd.arg;
    end

    assert_wr_single_R12: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |=> !wr_en_o);

endmodule

// File: rtl/id_sender.sv
module id_sender
    import cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       abort,
    input  logic       tx_ready,
    output logic       tx_valid_o,
    output logic [7:0] tx_data_o
);
    localparam logic [ID_IDX_W-1:0] LAST_IDX = ID_IDX_W'(ID_LEN - 1);

    logic                busy_q;
    logic [ID_IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
            end
        end else if (tx_ready) begin
            if (idx_q == LAST_IDX) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + ID_IDX_W'(1);
            end
        end
    end

    assign tx_valid_o = busy_q;
    assign tx_data_o  = ident_byte(idx_q);

    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready && !abort) |=> (tx_valid_o && $stable(tx_data_o)));

    assert_abort_drop_R8: assert property (@(posedge clk) disable iff (rst)
        abort |=> !tx_valid_o);

endmodule

// File: rtl/logic_cmd_decoder.sv
module logic_cmd_decoder
    import cmd_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int ADDR_W     = $clog2(FIXED_REGS + WORDS_PER_STAGE * NUM_STAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              run_pulse,
    output logic              reset_pulse,
    output logic              id_pulse,
    output logic              meta_pulse,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data
);
    logic       short_valid;
    logic [7:0] short_op;
    logic       long_valid;
    long_cmd_t  long_cmd;

    cmd_framer u_framer (
        .clk         (clk),
        .rst         (rst),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .short_valid (short_valid),
        .short_op    (short_op),
        .long_valid  (long_valid),
        .long_cmd    (long_cmd)
    );

    cmd_dispatch #(
        .NUM_STAGES (NUM_STAGES),
        .ADDR_W     (ADDR_W)
    ) u_dispatch (
        .clk         (clk),
        .rst         (rst),
        .short_valid (short_valid),
        .short_op    (short_op),
        .long_valid  (long_valid),
        .long_cmd    (long_cmd),
        .run_o       (run_pulse),
        .reset_o     (reset_pulse),
        .ident_o     (id_pulse),
        .meta_o      (meta_pulse),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data)
    );

    id_sender u_ident (
        .clk        (clk),
        .rst        (rst),
        .start      (id_pulse),
        .abort      (reset_pulse),
        .tx_ready   (tx_ready),
        .tx_valid_o (tx_valid),
        .tx_data_o  (tx_data)
    );

    assert_one_event_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, run_pulse, reset_pulse, id_pulse, meta_pulse}));

endmodule

// File: tb/logic_cmd_decoder_tb_top.sv
module logic_cmd_decoder_tb_top;
    localparam int NUM_STAGES = 4;
    localparam int ADDR_W     = $clog2(3 + 3 * NUM_STAGES);

    localparam int EV_WR = 0, EV_RUN = 1, EV_RST = 2, EV_ID = 3, EV_META = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst;
    logic              rx_valid;
    logic [7:0]        rx_data;
    logic              run_pulse, reset_pulse, id_pulse, meta_pulse;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0]       wr_data;
    logic              tx_valid;
    logic              tx_ready;
    logic [7:0]        tx_data;

    logic_cmd_decoder #(.NUM_STAGES(NUM_STAGES)) dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .run_pulse(run_pulse), .reset_pulse(reset_pulse), .id_pulse(id_pulse),
        .meta_pulse(meta_pulse), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
    );

    typedef struct {
        int          kind;
        int          addr;
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t        evq[$];
    logic [7:0]  txq[$];
    string       txreq[$];
    int          checks = 0;
    int          errors = 0;
    bit          ready_en = 1'b0;
    int          cyc = 0;
    bit          done = 1'b0;

    task automatic expect_ev(input int kind, input int addr, input logic [31:0] data, input string req);
        exp_t e;
        e.kind = kind; e.addr = addr; e.data = data; e.req = req;
        evq.push_back(e);
    endtask

    task automatic expect_ident(input string req);
        logic [7:0] b[4] = '{8'h31, 8'h53, 8'h4C, 8'h4F};
        foreach (b[i]) begin
            txq.push_back(b[i]);
            txreq.push_back(req);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_long(input logic [7:0] op, input logic [31:0] arg);
        send(op);
        for (int i = 3; i >= 0; i--) send(arg[8*i +: 8]);
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic got_ev(input int kind, input int addr, input logic [31:0] data);
        exp_t e;
        if (evq.size() == 0) begin
            checks++; errors++;
            $display("FAIL R11 unexpected strobe kind=%0d actual=0x%0h expected=none", kind, data);
        end else begin
            e = evq.pop_front();
            check(e.kind == kind, e.req, "strobe kind", kind, e.kind);
            if (kind == EV_WR && e.kind == EV_WR) begin
                check(e.addr == addr, e.req, "wr_addr", addr, e.addr);
                check(e.data == data, e.req, "wr_data", int'(data), int'(e.data));
            end
        end
    endtask

    // scoreboard monitor: drives tx_ready, then compares outputs
    always @(negedge clk) begin
        cyc++;
        tx_ready = ready_en && (cyc % 3 != 0);
        if (!rst && !done) begin
            if (wr_en)       got_ev(EV_WR, int'(wr_addr), wr_data);
            if (run_pulse)   got_ev(EV_RUN, 0, 32'd0);
            if (reset_pulse) got_ev(EV_RST, 0, 32'd0);
            if (id_pulse)    got_ev(EV_ID, 0, 32'd0);
            if (meta_pulse)  got_ev(EV_META, 0, 32'd0);
            if (tx_valid && tx_ready) begin
                if (txq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R8/R9 extra reply byte actual=0x%0h expected=none", tx_data);
                end else begin
                    check(tx_data == txq[0], txreq[0], "reply byte", tx_data, txq[0]);
                    void'(txq.pop_front());
                    void'(txreq.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_valid = 1'b0; rx_data = 8'h00; tx_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({wr_en, run_pulse, reset_pulse, id_pulse, meta_pulse, tx_valid} == 6'b0,
              "R12", "reset state", int'({wr_en, run_pulse, reset_pulse, id_pulse, meta_pulse, tx_valid}), 0);

        // short commands R1, R5, R6, R3
        expect_ev(EV_RUN, 0, 0, "R1/R5");  send(8'h01);
        expect_ev(EV_META, 0, 0, "R6");    send(8'h04);
        expect_ev(EV_RST, 0, 0, "R3");     send(8'h00);

        // long commands R2, R10
        expect_ev(EV_WR, 0, 32'h1234_5678, "R2/R10"); send_long(8'h80, 32'h1234_5678);
        expect_ev(EV_WR, 1, 32'h00FF_0003, "R2/R10"); send_long(8'h81, 32'h00FF_0003);
        expect_ev(EV_WR, 2, 32'h0000_003C, "R2/R10"); send_long(8'h82, 32'h0000_003C);
        for (int s = 0; s < NUM_STAGES; s++) begin
            for (int k = 0; k < 3; k++) begin
                expect_ev(EV_WR, 3 + 3 * s + k, {8'hA0 + 8'(s), 8'h5A, 8'(k), 8'hC3}, "R10");
                send_long(8'hC0 + 8'(4 * s + k), {8'hA0 + 8'(s), 8'h5A, 8'(k), 8'hC3});
            end
        end

        // unrecognised commands R11
        send_long(8'h83, 32'h0102_0480);
        send_long(8'hC3, 32'h0100_0201);
        send_long(8'hD0, 32'h0401_0200);
        send(8'h05);
        send(8'h7F);
        expect_ev(EV_RUN, 0, 0, "R11"); send(8'h01);

        // resynchronisation R4
        send(8'h81); send(8'h12);
        expect_ev(EV_WR, 1, 32'h1200_0000, "R4");
        expect_ev(EV_RST, 0, 0, "R4");
        expect_ev(EV_RST, 0, 0, "R4");
        repeat (5) send(8'h00);
        expect_ev(EV_RUN, 0, 0, "R4"); send(8'h01);
        send(8'hC5);
        expect_ev(EV_WR, 7, 32'h0, "R4");
        expect_ev(EV_RST, 0, 0, "R4");
        repeat (5) send(8'h00);
        expect_ev(EV_META, 0, 0, "R4"); send(8'h04);

        // identification reply with stalls R7
        ready_en = 1'b1;
        expect_ident("R7");
        expect_ev(EV_ID, 0, 0, "R7"); send(8'h02);
        repeat (40) @(negedge clk);
        check(txq.size() == 0, "R7", "reply bytes left", txq.size(), 0);

        // repeated request while pending R9
        ready_en = 1'b0;
        expect_ident("R9");
        expect_ev(EV_ID, 0, 0, "R9"); send(8'h02);
        expect_ev(EV_ID, 0, 0, "R9"); send(8'h02);
        ready_en = 1'b1;
        repeat (40) @(negedge clk);
        check(txq.size() == 0, "R9", "reply bytes left", txq.size(), 0);

        // cancellation R8
        ready_en = 1'b0;
        expect_ev(EV_ID, 0, 0, "R7"); send(8'h02);
        repeat (3) @(negedge clk);
        check(tx_valid == 1'b1, "R7", "tx_valid while stalled", int'(tx_valid), 1);
        check(tx_data == 8'h31, "R7", "first reply byte", tx_data, 8'h31);
        expect_ev(EV_RST, 0, 0, "R8"); send(8'h00);
        @(negedge clk);
        check(tx_valid == 1'b0, "R8", "tx_valid after cancel", int'(tx_valid), 0);
        ready_en = 1'b1;
        repeat (20) @(negedge clk);

        check(evq.size() == 0, "R11", "strobes still expected", evq.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule